// File: doc/BRIEF.md
# NAND Cell Change-Spacing and Response Timing Monitor

This block is a synthesizable runtime checker placed beside a two-input NAND-type cell. Every clock edge is one tick of a discrete time base. On each tick the monitor samples the cell's two inputs and its output, and it checks two separate rules.

The first rule is about the environment. After the input pair changes, it must stay quiet for a minimum number of ticks. The second rule is about the cell. After a legal input change, the output must reach the NAND of the inputs within a maximum delay. It must then keep that value for a hold window. The length of that window is derived from the spacing, maximum delay and minimum delay parameters.

A breach of either rule raises a one-sample event. The event also sets its own sticky flag, and the flag stays set until software-independent clear logic asserts `clr`. The cell is only judged while the environment keeps its side of the contract. Two generic history-window detectors do the work of finding changes and stretches of stability. One reports that a signal held still, the other that it moved.

Top module: `qt_nand_timing_mon`

## Requirements
- R1: While `rst_n` is low and on the first sample after its release, all five outputs are low. The first sample after reset only serves as the reference value, and no response window is open until a change event has been seen.
- R2: A change event is a sample on which `{a1,a0}` differs from the previous sample. `env_hit` is high on a change event when another change event occurred within the preceding GAP_MIN samples, that is at a distance of GAP_MIN or less. At a distance of GAP_MIN+1 or more the change is legal.
- R3: After a legal change event, `win_open` is high on the samples at distances DLY_MAX through DLY_MAX+HOLD from that change, as long as no further change occurs. Distance 0 is the change sample itself, and HOLD = GAP_MIN − DLY_MAX + DLY_MIN.
- R4: The output `y` is not judged outside the window. A mismatch at a distance below DLY_MAX or above DLY_MAX+HOLD never raises `cell_hit`.
- R5: `cell_hit` is high on a sample where `win_open` is high and `y` differs from NOT(`a0` AND `a1`).
- R6: A new change event closes any running window and restarts the distance count at 0. If that change is a spacing breach, no window opens for it and no `cell_hit` can occur until the next legal change.
- R7: `env_err` and `cell_err` go high on the clock after `env_hit` or `cell_hit` respectively. Each stays high until a sample with `clr` high and no new hit of its own kind. A hit in the same sample as `clr` keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock, one tick per edge |
| rst_n | input | 1 | Active-low reset of the monitor state |
| clr | input | 1 | Clears both sticky flags unless a new hit occurs |
| a0 | input | 1 | Cell input 0 as seen by the cell |
| a1 | input | 1 | Cell input 1 as seen by the cell |
| y | input | 1 | Cell output under observation |
| win_open | output | 1 | The output is being judged on this sample |
| env_hit | output | 1 | This sample is an input change that breaks spacing |
| cell_hit | output | 1 | This sample shows a wrong output inside the window |
| env_err | output | 1 | Sticky environment violation flag |
| cell_err | output | 1 | Sticky cell failure flag |

## Verification
The bench places input changes exactly GAP_MIN and GAP_MIN+1 samples apart. A monitor with an off-by-one spacing rule would either flag the legal case or pass the illegal one. It drives a wrong output one sample before the window opens and one sample after it closes, and a wrong output on its first and last samples. A window that is placed or sized wrongly shows up as a missing or a spurious `cell_hit`. It also presents a bad output after an illegal change, where a monitor that forgets to excuse the cell would raise `cell_hit`. Finally it asserts `clr` in the same sample as a new hit, which a monitor that lets clear win would lose.

// File: rtl/qt_pkg.sv
`timescale 1ns/1ps
package qt_pkg;

  // Length of the hold stretch that follows the settle deadline.
  function automatic int unsigned hold_len(input int unsigned gap_min,
                                           input int unsigned dly_max,
                                           input int unsigned dly_min);
    return gap_min - dly_max + dly_min;
  endfunction

  // Logic function the observed cell must implement.
  function automatic logic nand2(input logic a, input logic b);
    return ~(a & b);
  endfunction

endpackage

// File: rtl/qt_stable.sv
`timescale 1ns/1ps
// Reports that the current sample and the N samples before it are all equal.
// Samples not yet seen since reset count as agreeing. The report is given on
// the last sample of the window, so a shift of the window origin is immaterial.
module qt_stable #(
  parameter int W = 2,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x,
  output logic         hit
);
  logic [W-1:0] hist [N];
  logic [N-1:0] hv;

  always_ff @(posedge clk) begin
    if (!rst_n) hv <= '0;
    else begin
      hv[0] <= 1'b1;
      for (int i = 1; i < N; i++) hv[i] <= hv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    hist[0] <= x;
    for (int i = 1; i < N; i++) hist[i] <= hist[i-1];
  end

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < N; i++)
      if (hv[i] && hist[i] != x) hit = 1'b0;
  end
endmodule

// File: rtl/qt_change.sv
`timescale 1ns/1ps
// Reports that the sample N+1 steps back differs from at least one of the
// N+1 samples that follow it (the newest being the current one).
module qt_change #(
  parameter int W = 2,
  parameter int N = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x,
  output logic         hit
);
  logic [W-1:0] hist [N+1];
  logic [N:0]   hv;

  always_ff @(posedge clk) begin
    if (!rst_n) hv <= '0;
    else begin
      hv[0] <= 1'b1;
      for (int i = 1; i <= N; i++) hv[i] <= hv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    hist[0] <= x;
    for (int i = 1; i <= N; i++) hist[i] <= hist[i-1];
  end

  always_comb begin
    hit = (x != hist[N]);
    for (int i = 0; i < N; i++)
      if (hist[i] != hist[N]) hit = 1'b1;
    hit = hit & hv[N];
  end
endmodule

// File: rtl/qt_nand_timing_mon.sv
`timescale 1ns/1ps
module qt_nand_timing_mon #(
  parameter int unsigned GAP_MIN = 8,
  parameter int unsigned DLY_MAX = 3,
  parameter int unsigned DLY_MIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic a0,
  input  logic a1,
  input  logic y,
  output logic win_open,
  output logic env_hit,
  output logic cell_hit,
  output logic env_err,
  output logic cell_err
);
  localparam int unsigned HOLD  = qt_pkg::hold_len(GAP_MIN, DLY_MAX, DLY_MIN);
  localparam int unsigned LAST  = DLY_MAX + HOLD;
  localparam int          AGE_W = $clog2(LAST + 2);
  localparam logic [AGE_W-1:0] AGE_IDLE = AGE_W'(LAST + 1);
  localparam logic [AGE_W-1:0] AGE_OPEN = AGE_W'(DLY_MAX);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(LAST);

  initial begin
    if (DLY_MAX > GAP_MIN || DLY_MIN > DLY_MAX || GAP_MIN == 0)
      $fatal(1, "qt_nand_timing_mon: timing parameters out of order");
  end

  logic [1:0]       pair;
  logic             chg;        // input pair moved on this sample
  logic             quiet_now;  // last GAP_MIN+1 samples were all equal
  logic             quiet_q;    // same, as of the previous sample
  logic [AGE_W-1:0] age_q, age_now;
  logic             ok_q, ok_now;
  logic             want_y;

  assign pair = {a1, a0};

  qt_change #(.W(2), .N(0)) u_chg (
    .clk(clk), .rst_n(rst_n), .x(pair), .hit(chg)
  );

  qt_stable #(.W(2), .N(int'(GAP_MIN))) u_quiet (
    .clk(clk), .rst_n(rst_n), .x(pair), .hit(quiet_now)
  );

  always_comb begin
    age_now  = chg ? '0 : age_q;
    ok_now   = chg ? quiet_q : ok_q;
    want_y   = qt_pkg::nand2(a0, a1);
    env_hit  = chg & ~quiet_q;
    win_open = ok_now && (age_now >= AGE_OPEN) && (age_now <= AGE_LAST);
    cell_hit = win_open && (y != want_y);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q  <= 1'b1;
      age_q    <= AGE_IDLE;
      ok_q     <= 1'b0;
      env_err  <= 1'b0;
      cell_err <= 1'b0;
    end else begin
      quiet_q  <= quiet_now;
      age_q    <= (age_now == AGE_IDLE) ? AGE_IDLE : age_now + 1'b1;
      ok_q     <= ok_now;
      env_err  <= env_hit  | (env_err  & ~clr);
      cell_err <= cell_hit | (cell_err & ~clr);
    end
  end

  // R7: a breach is remembered from the next sample on
  p_env_flag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    env_hit |=> env_err);
  p_cell_flag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_hit |=> cell_err);
  // R7: flags only fall on a clear
  p_env_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    env_err && !clr |=> env_err);
  p_cell_flag_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !cell_hit |=> !cell_err);
  // R6: an illegal change never has its own response judged
  p_bad_change_excused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    env_hit |-> !win_open && !cell_hit);
  // R3: a window is open only on samples after a change, never on one
  p_window_not_at_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (DLY_MAX > 0) && win_open |-> !chg);
endmodule

// File: tb/qt_nand_timing_mon_tb.sv
`timescale 1ns/1ps
module qt_nand_timing_mon_tb;
  localparam int GAP  = 8;
  localparam int DMAX = 3;
  localparam int DMIN = 1;
  localparam int HOLD = GAP - DMAX + DMIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, a0 = 1'b0, a1 = 1'b0, y = 1'b1;
  logic win_open, env_hit, cell_hit, env_err, cell_err;

  always #2 clk = ~clk;

  qt_nand_timing_mon #(.GAP_MIN(GAP), .DLY_MAX(DMAX), .DLY_MIN(DMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .a0(a0), .a1(a1), .y(y),
    .win_open(win_open), .env_hit(env_hit), .cell_hit(cell_hit),
    .env_err(env_err), .cell_err(cell_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  int t = 0;
  bit have_prev = 1'b0;
  logic [1:0] prev_ab = 2'b00;
  int last_chg = -1;
  bit ok_last = 1'b0;
  bit m_env_err = 1'b0, m_cell_err = 1'b0;

  function automatic logic ref_nand(input logic [1:0] ab);
    return !(ab[1] && ab[0]);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at sample %0d", tag, act, exp, t);
    end
  endtask

  task automatic step(input logic [1:0] ab, input logic yv, input logic c);
    bit chg, legal, e_hit, ok, w, c_hit;
    int age;
    @(negedge clk);
    a1 = ab[1]; a0 = ab[0]; y = yv; clr = c;
    #1;
    chg   = have_prev && (ab != prev_ab);
    legal = (last_chg < 0) || (t - last_chg > GAP);
    e_hit = chg && !legal;
    if (chg) begin age = 0; ok = legal; end
    else begin age = (last_chg < 0) ? 100000 : t - last_chg; ok = ok_last; end
    w     = ok && age >= DMAX && age <= DMAX + HOLD;
    c_hit = w && (yv != ref_nand(ab));
    chk(env_hit,  e_hit,      "R2 env_hit");
    chk(win_open, w,          "R3/R6 win_open");
    chk(cell_hit, c_hit,      "R4/R5 cell_hit");
    chk(env_err,  m_env_err,  "R7 env_err");
    chk(cell_err, m_cell_err, "R7 cell_err");
    m_env_err  = e_hit | (m_env_err  & !c);
    m_cell_err = c_hit | (m_cell_err & !c);
    if (chg) begin last_chg = t; ok_last = legal; end
    prev_ab = ab; have_prev = 1'b1; t++;
  endtask

  task automatic hold(input int n, input logic [1:0] ab, input logic yv, input logic c);
    for (int i = 0; i < n; i++) step(ab, yv, c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] cur;
    logic [1:0] nh [32];
    int cd, k;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk); #1;
    chk(win_open, 1'b0, "R1 reset win_open");
    chk(env_hit,  1'b0, "R1 reset env_hit");
    chk(cell_hit, 1'b0, "R1 reset cell_hit");
    chk(env_err,  1'b0, "R1 reset env_err");
    chk(cell_err, 1'b0, "R1 reset cell_err");
    @(negedge clk); rst_n = 1'b1;
    // R1: first sample is only a reference, wrong y has no window yet
    hold(3, 2'b00, 1'b0, 1'b0);

    // R4 and R3: window edges after a legal change to 11 (nand 0)
    step(2'b11, 1'b1, 1'b0);              // distance 0, wrong but unjudged
    hold(2, 2'b11, 1'b1, 1'b0);           // distances 1..2 wrong, unjudged
    hold(HOLD + 1, 2'b11, 1'b0, 1'b0);    // distances 3..9 correct
    hold(2, 2'b11, 1'b1, 1'b0);           // beyond the window, unjudged
    hold(1, 2'b11, 1'b0, 1'b0);

    // R5: wrong output on first and last window sample
    step(2'b01, 1'b1, 1'b0);
    hold(DMAX - 1, 2'b01, 1'b1, 1'b0);
    step(2'b01, 1'b0, 1'b0);              // first window sample wrong
    hold(HOLD - 1, 2'b01, 1'b1, 1'b0);
    step(2'b01, 1'b0, 1'b0);              // last window sample wrong
    hold(3, 2'b01, 1'b1, 1'b0);

    // R2 and R6: change at distance GAP is illegal and excused
    step(2'b11, 1'b0, 1'b0);
    hold(GAP - 1, 2'b11, 1'b0, 1'b0);
    step(2'b10, 1'b0, 1'b0);              // illegal, wrong y excused
    hold(12, 2'b10, 1'b0, 1'b0);          // window never opens
    // R2: change at distance GAP+1 is legal
    step(2'b00, 1'b1, 1'b0);
    hold(GAP, 2'b00, 1'b1, 1'b0);
    step(2'b11, 1'b0, 1'b0);
    hold(DMAX - 1, 2'b11, 1'b0, 1'b0);
    // R7: hit in the same sample as clr keeps the flag
    step(2'b11, 1'b1, 1'b1);
    step(2'b11, 1'b0, 1'b0);
    chk(cell_err, 1'b1, "R7 set wins over clear");
    step(2'b11, 1'b0, 1'b1);
    step(2'b11, 1'b0, 1'b0);
    chk(cell_err, 1'b0, "R7 clear without hit");
    chk(env_err,  1'b0, "R7 env clear without hit");
    hold(GAP, 2'b11, 1'b0, 1'b0);

    // random phase
    cur = 2'b11; cd = 1; k = 0;
    for (int i = 0; i < 6000; i++) begin
      int ph, d;
      logic yv;
      ph = (i / 500) % 3;
      cd--;
      if (cd <= 0) begin
        cur = cur ^ 2'($urandom_range(1, 3));
        cd = ($urandom_range(0, 9) < 8) ? GAP + 1 + int'($urandom_range(0, 4))
                                        : int'($urandom_range(1, GAP));
      end
      nh[k % 32] = cur;
      if (ph == 0)      d = int'($urandom_range(0, DMAX));
      else if (ph == 1) d = DMAX + 1;
      else              d = DMAX;
      yv = (k >= d) ? ref_nand(nh[(k - d) % 32]) : ref_nand(cur);
      if (ph == 2 && $urandom_range(0, 19) == 0) yv = !yv;
      step(cur, yv, $urandom_range(0, 49) == 0);
      k++;
    end
    finish_run();
  end
endmodule